// File: doc/BRIEF.md
# Serial Register Control Port

This block is a synchronous serial slave that lets a host read and write a small byte-wide register file. The host lowers the chip-select line, clocks a 16-bit instruction into the port, and then moves data bytes. The instruction holds a direction bit, a two-bit length code and a 13-bit register address. Length codes select one, two or three bytes, or an open-ended stream that lasts until chip select rises. The port can shift in either bit order, and the address walks down or up from byte to byte to match that order.

All serial inputs are oversampled in the system clock domain. Each input passes through a short synchronizer, and edges of the serial clock are detected in that domain. Input bits are taken on rising serial-clock edges. Read bits are launched after falling edges, either on the bidirectional data line or on a dedicated output line. A configuration byte at address 0 selects the bit order, the output line and a sticky soft reset. Writes to the buffered register bank go to shadow copies and reach the active outputs only when the update input is pulsed. A separate self-clearing register produces one-cycle reset pulses.

Top module: `spi_regport`

## Requirements
- R1: The instruction is 16 bits: bit 15 is direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 the start address. In MSB-first order bit 15 is shifted first; in LSB-first order bit 0 is shifted first, and data bytes follow the same order.
- R2: Length codes 0, 1 and 2 transfer exactly 1, 2 and 3 data bytes; further bytes clocked in the same transaction are ignored.
- R3: Length code 3 streams bytes for as long as chip select stays low.
- R4: After each data byte the address decrements in MSB-first order and increments in LSB-first order, wrapping at 13 bits.
- R5: At address 0 the low nibble of a written byte sets bit 0 = output on the dedicated line, bit 1 = LSB-first order, bit 2 = soft reset; the upper nibble is ignored. A read returns the nibble with bit 3 forced to 1 in bits 3:0, and its bit-reversed copy in bits 7:4. The new setting applies from the next byte onward.
- R6: The soft-reset output follows configuration bit 2 and stays high until that bit is written back to 0.
- R7: Writing the reset register (default address 0x0012) with bit i set drives pulse output i high for exactly one system clock. The register always reads 0.
- R8: Writes to the buffered bank (default 0x0100 to 0x0103) land in shadow registers. The active outputs and read-back change only on a system clock where the update input is high.
- R9: Read bits appear on the bidirectional line, with its enable high, only in the data bytes of a read while the dedicated-line bit is clear. When that bit is set they appear on the dedicated line with its own enable instead. Both enables are low at all other times.
- R10: Raising chip select at any point abandons the transaction. A partly shifted byte is not written, and the next transaction begins with a fresh instruction.
- R11: After reset, both output enables, the soft reset, the pulses and all active registers are 0, and the configuration byte reads 0x18.
- R12: Reads of addresses that map to no register return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; serial lines are oversampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| csb_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in (bidirectional line, input side) |
| sdio_o | output | 1 | Read data on the bidirectional line |
| sdio_oe_o | output | 1 | Drive enable for the bidirectional line |
| sdo_o | output | 1 | Read data on the dedicated output line |
| sdo_oe_o | output | 1 | Drive enable for the dedicated output line |
| update_i | input | 1 | Copies all shadow registers into the active registers |
| soft_rst_o | output | 1 | Sticky soft reset from the configuration byte |
| pulse_o | output | PULSE_W | One-cycle self-clearing reset pulses |
| active_o | output | NREG*8 | Active register contents, register i in bits 8i+7:8i |

## Verification
A behavioural host drives single-byte, fixed three-byte and streaming transfers in both bit orders. Multi-byte accesses are aimed at the edges of the buffered bank, so a wrong address direction, a missing order swap or a wrong byte count lands a byte in a different register. Overlong fixed-length writes and transfers cut short in the instruction or mid-byte show whether surplus or partial bits leak into a register. Reads before and after the update pulse, and reads with the output steered to each line, separate shadow from active data and the two output paths.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 13;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_IDLE} phase_e;

  typedef struct packed {
    logic              rd;
    logic [1:0]        len;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  function automatic logic [3:0] rev4(input logic [3:0] n);
    return {n[0], n[1], n[2], n[3]};
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= RST_VAL;
    end else begin
      st_q[0] <= in_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign out_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_regport_engine.sv
module spi_regport_engine
  import spi_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              csb_s_i,
  input  logic              sdi_s_i,
  input  logic              lsb_first_i,
  input  logic              sdo_active_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [7:0]        wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  phase_e              phase_q;
  logic [3:0]          bit_cnt_q;
  logic [1:0]          byte_cnt_q;
  logic [INSTR_W-1:0]  sh_q, sh_next;
  instr_t              ins_q, ins_next;
  logic                sclk_d_q, out_bit_q;
  logic                rise, fall, byte_end;
  logic [2:0]          rd_idx;

  assign rise     = sclk_s_i & ~sclk_d_q & ~csb_s_i;
  assign fall     = ~sclk_s_i & sclk_d_q & ~csb_s_i;
  assign sh_next  = lsb_first_i ? {sdi_s_i, sh_q[INSTR_W-1:1]} : {sh_q[INSTR_W-2:0], sdi_s_i};
  assign ins_next = sh_next;
  assign byte_end = (phase_q == PH_DATA) && (bit_cnt_q == 4'd7);
  assign rd_idx   = lsb_first_i ? bit_cnt_q[2:0] : ~bit_cnt_q[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q   <= 1'b0;
      phase_q    <= PH_INSTR;
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      sh_q       <= '0;
      ins_q      <= '0;
      out_bit_q  <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s_i;
      if (csb_s_i) begin
        phase_q    <= PH_INSTR;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
      end else if (rise) begin
        sh_q <= sh_next;
        case (phase_q)
          PH_INSTR: begin
            if (bit_cnt_q == 4'(INSTR_W-1)) begin
              ins_q      <= ins_next;
              phase_q    <= PH_DATA;
              bit_cnt_q  <= '0;
              byte_cnt_q <= '0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          PH_DATA: begin
            if (byte_end) begin
              bit_cnt_q  <= '0;
              ins_q.addr <= lsb_first_i ? ins_q.addr + 1'b1 : ins_q.addr - 1'b1;
              if (ins_q.len != 2'd3 && byte_cnt_q == ins_q.len) phase_q <= PH_IDLE;
              else if (byte_cnt_q != 2'd3) byte_cnt_q <= byte_cnt_q + 2'd1;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
          default: ;
        endcase
      end else if (fall && phase_q == PH_DATA && ins_q.rd) begin
        out_bit_q <= rd_data_i[rd_idx];
      end
    end
  end

  assign addr_o    = ins_q.addr;
  assign wr_en_o   = rise && byte_end && !ins_q.rd;
  assign wr_data_o = lsb_first_i ? sh_next[15:8] : sh_next[7:0];

  logic rd_act;
  assign rd_act    = ~csb_s_i && (phase_q == PH_DATA) && ins_q.rd;
  assign sdio_oe_o = rd_act & ~sdo_active_i;
  assign sdo_oe_o  = rd_act & sdo_active_i;
  assign sdio_o    = out_bit_q;
  assign sdo_o     = out_bit_q;

  // R10
  csb_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_s_i |=> (phase_q == PH_INSTR && bit_cnt_q == 4'd0));
  // R9
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));
  // R2
  byte_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (ins_q.len == 2'd3 || byte_cnt_q <= ins_q.len));
  // R9
  no_drive_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_DATA) |-> !(sdio_oe_o || sdo_oe_o));
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter int                NREG     = 4,
  parameter logic [ADDR_W-1:0] BUF_BASE = 13'h0100,
  parameter logic [ADDR_W-1:0] RST_ADDR = 13'h0012,
  parameter int                PULSE_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              update_i,
  output logic [7:0]        rd_data_o,
  output logic              sdo_active_o,
  output logic              lsb_first_o,
  output logic              soft_rst_o,
  output logic [PULSE_W-1:0] pulse_o,
  output logic [NREG*8-1:0] active_o
);
  logic [2:0]         cfg_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [7:0]         active_q [NREG];
  logic [3:0]         cfg_nib;
  logic               cfg_we;

  assign cfg_we  = wr_en_i && (addr_i == '0);
  assign cfg_nib = {1'b1, cfg_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      pulse_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= wr_data_i[2:0];
      pulse_q <= (wr_en_i && addr_i == RST_ADDR) ? wr_data_i[PULSE_W-1:0] : '0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_buf
    localparam logic [ADDR_W-1:0] REG_A = BUF_BASE + ADDR_W'(i);
    logic [7:0] shadow_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q    <= '0;
        active_q[i] <= '0;
      end else begin
        if (wr_en_i && addr_i == REG_A) shadow_q <= wr_data_i;
        if (update_i) active_q[i] <= shadow_q;
      end
    end
    assign active_o[i*8 +: 8] = active_q[i];
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == '0) rd_data_o = {rev4(cfg_nib), cfg_nib};
    for (int i = 0; i < NREG; i++)
      if (addr_i == BUF_BASE + ADDR_W'(i)) rd_data_o = active_q[i];
  end

  assign sdo_active_o = cfg_q[0];
  assign lsb_first_o  = cfg_q[1];
  assign soft_rst_o   = cfg_q[2];
  assign pulse_o      = pulse_q;

  // R7
  pulse_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_q) |=> (pulse_q == '0));
  // R8
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(active_o));
  // R6
  soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we |=> $stable(soft_rst_o));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int                NREG        = 4,
  parameter logic [ADDR_W-1:0] BUF_BASE    = 13'h0100,
  parameter logic [ADDR_W-1:0] RST_ADDR    = 13'h0012,
  parameter int                PULSE_W     = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               csb_i,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe_o,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  input  logic               update_i,
  output logic               soft_rst_o,
  output logic [PULSE_W-1:0] pulse_o,
  output logic [NREG*8-1:0]  active_o
);
  logic [2:0]        sync_out;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, lsb_first, sdo_active;
  logic [7:0]        wr_data, rd_data;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({csb_i, sclk_i, sdio_i}),
    .out_o (sync_out)
  );

  spi_regport_engine u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (sync_out[1]),
    .csb_s_i     (sync_out[2]),
    .sdi_s_i     (sync_out[0]),
    .lsb_first_i (lsb_first),
    .sdo_active_i(sdo_active),
    .rd_data_i   (rd_data),
    .addr_o      (addr),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  spi_regport_regs #(
    .NREG(NREG), .BUF_BASE(BUF_BASE), .RST_ADDR(RST_ADDR), .PULSE_W(PULSE_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .update_i    (update_i),
    .rd_data_o   (rd_data),
    .sdo_active_o(sdo_active),
    .lsb_first_o (lsb_first),
    .soft_rst_o  (soft_rst_o),
    .pulse_o     (pulse_o),
    .active_o    (active_o)
  );
endmodule

// File: tb/tb_spi_regport.sv
module tb_spi_regport;
  localparam int          NREG     = 4;
  localparam logic [12:0] BUF_BASE = 13'h0100;
  localparam logic [12:0] RST_ADDR = 13'h0012;
  localparam int          PW       = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, sdio = 1'b0, upd = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, soft_rst;
  logic [PW-1:0]     pulse;
  logic [NREG*8-1:0] active;

  spi_regport dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_i(csb), .sdio_i(sdio),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe),
    .update_i(upd), .soft_rst_o(soft_rst), .pulse_o(pulse), .active_o(active)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] m_sh [NREG];
  logic [7:0] m_act [NREG];
  logic m_sdo = 1'b0, m_lsb = 1'b0, m_soft = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  int pcnt [PW];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    logic [3:0] n;
    n = {1'b1, m_soft, m_lsb, m_sdo};
    if (a == 13'h0) return {n[0], n[1], n[2], n[3], n};
    for (int i = 0; i < NREG; i++) if (a == BUF_BASE + 13'(i)) return m_act[i];
    return 8'h00;
  endfunction

  function automatic void model_wr(input logic [12:0] a, input logic [7:0] b);
    if (a == 13'h0) begin
      m_sdo = b[0]; m_lsb = b[1]; m_soft = b[2];
    end
    for (int i = 0; i < NREG; i++) if (a == BUF_BASE + 13'(i)) m_sh[i] = b;
  endfunction

  // reference active bank follows the update strobe
  always @(posedge clk) if (upd) for (int i = 0; i < NREG; i++) m_act[i] <= m_sh[i];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NREG; i++) chk("R8 active_o", 32'(active[i*8 +: 8]), 32'(m_act[i]));
      for (int i = 0; i < PW; i++) pcnt[i] += int'(pulse[i]);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b0; sdio = b; wait_clk(4);
    sclk = 1'b1; wait_clk(4);
  endtask

  task automatic xfer(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                      input int nb, input int extra, input string req);
    logic [15:0] ins;
    logic [12:0] a;
    logic        old_lsb;
    int          lim, idx;
    ins = {rd, len, addr};
    a   = addr;
    lim = (len == 2'd3) ? 1000 : int'(len) + 1;
    csb = 1'b0; wait_clk(3);
    for (int i = 0; i < 16; i++) bit_out(ins[m_lsb ? i : 15 - i]);
    for (int k = 0; k < nb; k++) begin
      for (int j = 0; j < 8; j++) begin
        idx = m_lsb ? j : 7 - j;
        if (rd) begin
          sclk = 1'b0; wait_clk(4);
          if (j == 0)
            chk({req, " R9 enables"}, {30'd0, sdio_oe, sdo_oe},
                {30'd0, (k < lim) && !m_sdo, (k < lim) && m_sdo});
          rbuf[k][idx] = m_sdo ? sdo_o : sdio_o;
          sclk = 1'b1; wait_clk(4);
        end else begin
          bit_out(wbuf[k][idx]);
        end
      end
      if (k < lim) begin
        old_lsb = m_lsb;
        if (rd) chk({req, " read byte"}, 32'(rbuf[k]), 32'(exp_rd(a)));
        else model_wr(a, wbuf[k]);
        a = old_lsb ? a + 13'd1 : a - 13'd1;
      end
    end
    for (int e = 0; e < extra; e++) bit_out(1'b1);
    sclk = 1'b0; wait_clk(2);
    csb = 1'b1; wait_clk(8);
  endtask

  task automatic pulse_update();
    upd = 1'b1; wait_clk(1);
    upd = 1'b0; wait_clk(2);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    for (int i = 0; i < PW; i++) pcnt[i] = 0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);

    // R11 reset state
    chk("R11 enables", {30'd0, sdio_oe, sdo_oe}, 32'd0);
    chk("R11 soft_rst", 32'(soft_rst), 32'd0);
    chk("R11 pulse", 32'(pulse), 32'd0);
    chk("R11 active", 32'(active), 32'd0);
    // R11 R5 R1 config read MSB-first
    xfer(1'b1, 2'd0, 13'h0000, 1, 0, "R11 R5 R1 cfg");

    // R2 R4 three-byte write, address decrements
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    xfer(1'b0, 2'd2, BUF_BASE + 13'd3, 3, 0, "R4 wr");
    // R8 shadow not visible before update
    xfer(1'b1, 2'd0, BUF_BASE + 13'd3, 1, 0, "R8 pre-update");
    pulse_update();
    xfer(1'b1, 2'd2, BUF_BASE + 13'd3, 3, 0, "R4 R2 rd");

    // R2 extra byte beyond single-byte code ignored
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    xfer(1'b0, 2'd0, BUF_BASE + 13'd1, 2, 0, "R2 wr");
    pulse_update();
    // R3 streaming read of four bytes
    xfer(1'b1, 2'd3, BUF_BASE + 13'd3, 4, 0, "R3 R2 stream");

    // R7 self-clearing pulses
    for (int i = 0; i < PW; i++) pcnt[i] = 0;
    wbuf[0] = 8'h03;
    xfer(1'b0, 2'd0, RST_ADDR, 1, 0, "R7 wr");
    for (int i = 0; i < PW; i++) chk("R7 pulse count", 32'(pcnt[i]), 32'd1);
    xfer(1'b1, 2'd0, RST_ADDR, 1, 0, "R7 rd");

    // R6 sticky soft reset
    wbuf[0] = 8'h24;
    xfer(1'b0, 2'd0, 13'h0000, 1, 0, "R6 set");
    wait_clk(20);
    chk("R6 soft high", 32'(soft_rst), 32'd1);
    chk("R6 soft held", 32'(soft_rst), 32'(m_soft));
    wbuf[0] = 8'h00;
    xfer(1'b0, 2'd0, 13'h0000, 1, 0, "R6 clr");
    chk("R6 soft low", 32'(soft_rst), 32'd0);

    // R9 read through dedicated line
    wbuf[0] = 8'h81;
    xfer(1'b0, 2'd0, 13'h0000, 1, 0, "R9 cfg");
    xfer(1'b1, 2'd1, BUF_BASE + 13'd3, 2, 0, "R9 sdo rd");
    wbuf[0] = 8'h00;
    xfer(1'b0, 2'd0, 13'h0000, 1, 0, "R9 cfg back");
    chk("R9 idle enables", {30'd0, sdio_oe, sdo_oe}, 32'd0);

    // R1 R4 R10 LSB-first streaming write with a torn fourth byte
    wbuf[0] = 8'h42;
    xfer(1'b0, 2'd0, 13'h0000, 1, 0, "R5 lsb cfg");
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2; wbuf[2] = 8'hD3;
    xfer(1'b0, 2'd3, BUF_BASE, 3, 4, "R10 torn");
    pulse_update();
    xfer(1'b1, 2'd3, BUF_BASE, 4, 0, "R4 R3 R1 lsb stream");
    xfer(1'b1, 2'd0, 13'h0000, 1, 0, "R5 cfg lsb");

    // R10 abort inside instruction, then a clean transaction
    csb = 1'b0; wait_clk(3);
    for (int i = 0; i < 7; i++) bit_out(1'b1);
    sclk = 1'b0; wait_clk(2); csb = 1'b1; wait_clk(8);
    xfer(1'b1, 2'd0, BUF_BASE + 13'd2, 1, 0, "R10 after abort");
    // R12 unmapped address
    xfer(1'b1, 2'd0, 13'h0050, 1, 0, "R12 unmapped");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule